// File: doc/BRIEF.md
# Audio Sample Word Unpacker

This block sits between a bus master (a DMA engine or a processor) and a sound converter interface. The master writes 32-bit words of sound data. Each strobe from the converter side takes the next piece of the held word and puts it on a 16-bit sample output. In stereo mode a word yields two 16-bit samples. In mono mode it yields four 8-bit samples.

A level request asks the master for the next word. The request is raised halfway through the current word, so the next word can arrive before the current one runs out. Each new word lands in a staging register. It moves into the active register when the last piece of the current word is consumed, so consecutive words play with no lost slot.

A control enable gates all activity. Dropping it empties both registers, clears the request and rewinds to the first piece. A sticky flag reports any strobe that found no data.

Top module: `sound_word_unpacker`

## Requirements
- R1: After reset, `sampleOut` is 0, `dataReq` is 0 and `underrun` is 0.
- R2: While `enable` is 0, writes on `wrEn` are ignored: after re-enabling, a strobe finds no data. It sets `underrun` and leaves `sampleOut` at 0.
- R3: In stereo mode (`monoMode`=0), the first strobe on a word outputs `wrData[15:0]` and the second outputs `wrData[31:16]`. Each appears on `sampleOut` the cycle after its strobe.
- R4: In mono mode (`monoMode`=1), four strobes output bytes 0, 1, 2 and 3 of the word, in that order. Bits [7:0] are byte 0. Each byte appears on `sampleOut[15:8]`, with `sampleOut[7:0]` at 0.
- R5: `dataReq` rises the cycle after the strobe that consumes the last piece of the lower half. That is the first piece in stereo mode and the second piece in mono mode. It stays low after earlier pieces.
- R6: `dataReq` is a level. It stays high through idle cycles and falls in the cycle after an accepted write (`enable`=1 and `wrEn`=1). An accepted write wins over a request set in the same cycle.
- R7: A word written while the current word is still being consumed is output starting with the strobe after the current word's last piece, with no gap.
- R8: A strobe that finds no active or staged data leaves `sampleOut` unchanged and sets `underrun`. The flag stays set until a cycle with `underrunClr`=1. A new underrun in that same cycle keeps the flag set.
- R9: Driving `enable` to 0 clears `sampleOut` and `dataReq` in the next cycle. It also discards both held words and returns the piece pointer to the first piece.
- R10: With `enable`=1, `sampleOut` changes only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Control enable; gates writes and strobes, flushes when low |
| wrEn | input | 1 | Data word write strobe |
| wrData | input | 32 | Data word |
| monoMode | input | 1 | 1 = 8-bit mono pieces, 0 = 16-bit stereo pieces |
| sampleStrobe | input | 1 | Consume one piece |
| underrunClr | input | 1 | Clears the underrun flag |
| sampleOut | output | 16 | Current sample |
| dataReq | output | 1 | Request for the next word |
| underrun | output | 1 | Sticky underrun flag |

## Verification
On every cycle, the assertions check these rules:
- the request falls after each accepted write;
- a disable flushes the outputs;
- the underrun flag is sticky and only rises on a strobe;
- the sample output stays still whenever no strobe arrives.

The piece order in each mode, the timing of the request relative to the lower half, and the seamless handover from staged to active word need the values that were written. Only the bench scenarios can show them. They sweep several words in both modes with expected pieces computed from each word.

// File: rtl/sdu_pkg.sv
package sdu_pkg;
  localparam int DATA_W   = 32;
  localparam int SAMPLE_W = 16;
  localparam int PTR_W    = $clog2(DATA_W / (SAMPLE_W / 2));

  typedef struct packed {
    logic              flush;
    logic              capture;
    logic              promote;
    logic              emit;
    logic              fromStage;
    logic [PTR_W-1:0]  idx;
    logic              mono;
  } sduCtrl_t;
endpackage

// File: rtl/sdu_control.sv
module sdu_control
  import sdu_pkg::*;
#(
  parameter int DATA_W   = sdu_pkg::DATA_W,
  parameter int SAMPLE_W = sdu_pkg::SAMPLE_W
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  logic     wrEn,
  input  logic     monoMode,
  input  logic     sampleStrobe,
  input  logic     underrunClr,
  output sduCtrl_t ctrl,
  output logic     dataReq,
  output logic     underrun
);
  localparam int BYTE_W        = SAMPLE_W / 2;
  localparam int STEREO_PIECES = DATA_W / SAMPLE_W;
  localparam int MONO_PIECES   = DATA_W / BYTE_W;

  logic [PTR_W-1:0] ptrQ, ptrD;
  logic stageValidQ, stageValidD;
  logic activeValidQ, activeValidD;
  logic reqQ, reqD;
  logic underQ, underD;
  logic accept, stageTaken, underSet, reqSet;
  logic [PTR_W-1:0] lastIdx, lowLastIdx;

  assign accept     = enable && wrEn;
  assign lastIdx    = monoMode ? PTR_W'(MONO_PIECES - 1) : PTR_W'(STEREO_PIECES - 1);
  assign lowLastIdx = monoMode ? PTR_W'(MONO_PIECES / 2 - 1) : PTR_W'(STEREO_PIECES / 2 - 1);

  always_comb begin
    ctrl         = '0;
    ctrl.mono    = monoMode;
    ctrl.capture = accept;
    ptrD         = ptrQ;
    activeValidD = activeValidQ;
    stageTaken   = 1'b0;
    underSet     = 1'b0;
    if (!enable) begin
      ctrl.flush   = 1'b1;
      ptrD         = '0;
      activeValidD = 1'b0;
    end else if (sampleStrobe) begin
      if (activeValidQ) begin
        ctrl.emit = 1'b1;
        ctrl.idx  = ptrQ;
        if (ptrQ >= lastIdx) begin
          ptrD         = '0;
          activeValidD = stageValidQ;
          stageTaken   = stageValidQ;
          ctrl.promote = stageValidQ;
        end else begin
          ptrD = ptrQ + 1'b1;
        end
      end else if (stageValidQ) begin
        ctrl.emit      = 1'b1;
        ctrl.fromStage = 1'b1;
        ctrl.idx       = '0;
        ctrl.promote   = 1'b1;
        stageTaken     = 1'b1;
        activeValidD   = 1'b1;
        ptrD           = PTR_W'(1);
      end else begin
        underSet = 1'b1;
      end
    end
  end

  assign reqSet = ctrl.emit && (ctrl.idx == lowLastIdx);

  always_comb begin
    if (!enable)         stageValidD = 1'b0;
    else if (accept)     stageValidD = 1'b1;
    else if (stageTaken) stageValidD = 1'b0;
    else                 stageValidD = stageValidQ;

    if (!enable || accept) reqD = 1'b0;
    else if (reqSet)       reqD = 1'b1;
    else                   reqD = reqQ;

    if (underSet)         underD = 1'b1;
    else if (underrunClr) underD = 1'b0;
    else                  underD = underQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ         <= '0;
      stageValidQ  <= 1'b0;
      activeValidQ <= 1'b0;
      reqQ         <= 1'b0;
      underQ       <= 1'b0;
    end else begin
      ptrQ         <= ptrD;
      stageValidQ  <= stageValidD;
      activeValidQ <= activeValidD;
      reqQ         <= reqD;
      underQ       <= underD;
    end
  end

  assign dataReq  = reqQ;
  assign underrun = underQ;
endmodule

// File: rtl/sdu_datapath.sv
module sdu_datapath
  import sdu_pkg::*;
#(
  parameter int DATA_W   = sdu_pkg::DATA_W,
  parameter int SAMPLE_W = sdu_pkg::SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  sduCtrl_t            ctrl,
  input  logic [DATA_W-1:0]   wrData,
  output logic [SAMPLE_W-1:0] sampleOut
);
  localparam int BYTE_W        = SAMPLE_W / 2;
  localparam int STEREO_PIECES = DATA_W / SAMPLE_W;

  logic [DATA_W-1:0]   stageWordQ, activeWordQ, srcWord;
  logic [SAMPLE_W-1:0] sampleQ, pieceVal;
  logic [BYTE_W-1:0]   bytePiece;

  assign srcWord   = ctrl.fromStage ? stageWordQ : activeWordQ;
  assign bytePiece = srcWord[int'(ctrl.idx) * BYTE_W +: BYTE_W];

  always_comb begin
    if (ctrl.mono) pieceVal = {bytePiece, {BYTE_W{1'b0}}};
    else           pieceVal = srcWord[(int'(ctrl.idx) % STEREO_PIECES) * SAMPLE_W +: SAMPLE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageWordQ  <= '0;
      activeWordQ <= '0;
      sampleQ     <= '0;
    end else if (ctrl.flush) begin
      stageWordQ  <= '0;
      activeWordQ <= '0;
      sampleQ     <= '0;
    end else begin
      if (ctrl.capture) stageWordQ  <= wrData;
      if (ctrl.promote) activeWordQ <= stageWordQ;
      if (ctrl.emit)    sampleQ     <= pieceVal;
    end
  end

  assign sampleOut = sampleQ;
endmodule

// File: rtl/sound_word_unpacker.sv
module sound_word_unpacker
  import sdu_pkg::*;
#(
  parameter int DATA_W   = sdu_pkg::DATA_W,
  parameter int SAMPLE_W = sdu_pkg::SAMPLE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                monoMode,
  input  logic                sampleStrobe,
  input  logic                underrunClr,
  output logic [SAMPLE_W-1:0] sampleOut,
  output logic                dataReq,
  output logic                underrun
);
  sduCtrl_t ctrl;

  sdu_control #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn),
    .monoMode(monoMode), .sampleStrobe(sampleStrobe),
    .underrunClr(underrunClr), .ctrl(ctrl), .dataReq(dataReq),
    .underrun(underrun)
  );

  sdu_datapath #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .wrData(wrData),
    .sampleOut(sampleOut)
  );
endmodule

// File: rtl/sdu_checker.sv
module sdu_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                enable,
  input logic                wrEn,
  input logic                sampleStrobe,
  input logic                underrunClr,
  input logic [SAMPLE_W-1:0] sampleOut,
  input logic                dataReq,
  input logic                underrun
);
  AST_REQ_DROP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && wrEn) |=> !dataReq); // R6
  AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!dataReq && sampleOut == '0)); // R9
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && !underrunClr) |=> underrun); // R8
  AST_UNDERRUN_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $past(sampleStrobe && enable)); // R8
  AST_UNDERRUN_HOLDS_SAMPLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> $stable(sampleOut)); // R8
  AST_SAMPLE_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !sampleStrobe) |=> $stable(sampleOut)); // R10
endmodule

bind sound_word_unpacker sdu_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn),
  .sampleStrobe(sampleStrobe), .underrunClr(underrunClr),
  .sampleOut(sampleOut), .dataReq(dataReq), .underrun(underrun)
);

// File: tb/sound_word_unpacker_tb.sv
`timescale 1ns/1ps
module sound_word_unpacker_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, wrEn = 1'b0, monoMode = 1'b0;
  logic sampleStrobe = 1'b0, underrunClr = 1'b0;
  logic [31:0] wrData = '0;
  logic [15:0] sampleOut;
  logic dataReq, underrun;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  sound_word_unpacker dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .wrEn(wrEn), .wrData(wrData),
    .monoMode(monoMode), .sampleStrobe(sampleStrobe), .underrunClr(underrunClr),
    .sampleOut(sampleOut), .dataReq(dataReq), .underrun(underrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic writeWord(input logic [31:0] w);
    wrEn = 1'b1; wrData = w;
    cyc();
    wrEn = 1'b0;
  endtask

  task automatic strobe();
    sampleStrobe = 1'b1;
    cyc();
    sampleStrobe = 1'b0;
  endtask

  function automatic logic [31:0] mkWord(input int k);
    return 32'hA5C3_1E70 ^ (32'(k) * 32'h0107_0309 + 32'(k));
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    logic [15:0] lastS;
    cyc(); cyc();
    rstN = 1'b1;
    cyc();
    check("R1 sampleOut", 32'(sampleOut), 0);
    check("R1 dataReq", 32'(dataReq), 0);
    check("R1 underrun", 32'(underrun), 0);

    // R2: disabled write ignored
    writeWord(32'hDEAD_BEEF);
    enable = 1'b1; cyc();
    strobe();
    check("R2 underrun", 32'(underrun), 1);
    check("R2 sampleOut", 32'(sampleOut), 0);
    underrunClr = 1'b1; cyc(); underrunClr = 1'b0;
    check("R8 clear", 32'(underrun), 0);

    // stereo sweep
    monoMode = 1'b0;
    writeWord(mkWord(0));
    for (int k = 0; k < 6; k++) begin
      w = mkWord(k);
      strobe();
      check("R3 low half", 32'(sampleOut), 32'(w[15:0]));
      check("R5 stereo req", 32'(dataReq), 1);
      cyc();
      check("R6 req held", 32'(dataReq), 1);
      check("R10 stable", 32'(sampleOut), 32'(w[15:0]));
      if (k < 5) begin
        writeWord(mkWord(k + 1));
        check("R6 req drop", 32'(dataReq), 0);
      end
      strobe();
      check("R3 high half", 32'(sampleOut), 32'(w[31:16]));
      if (k < 5) check("R7 no underrun", 32'(underrun), 0);
    end
    lastS = sampleOut;
    strobe();
    check("R8 underrun set", 32'(underrun), 1);
    check("R8 repeat sample", 32'(sampleOut), 32'(lastS));
    strobe(); cyc();
    check("R8 sticky", 32'(underrun), 1);
    sampleStrobe = 1'b1; underrunClr = 1'b1; cyc();
    sampleStrobe = 1'b0; underrunClr = 1'b0;
    check("R8 set wins", 32'(underrun), 1);
    underrunClr = 1'b1; cyc(); underrunClr = 1'b0;
    check("R8 cleared", 32'(underrun), 0);

    // mono sweep
    monoMode = 1'b1;
    writeWord(mkWord(20));
    for (int k = 20; k < 26; k++) begin
      w = mkWord(k);
      strobe();
      check("R4 byte0", 32'(sampleOut), 32'({w[7:0], 8'h00}));
      check("R5 mono no req yet", 32'(dataReq), 0);
      strobe();
      check("R4 byte1", 32'(sampleOut), 32'({w[15:8], 8'h00}));
      check("R5 mono req", 32'(dataReq), 1);
      if (k < 25) writeWord(mkWord(k + 1));
      strobe();
      check("R4 byte2", 32'(sampleOut), 32'({w[23:16], 8'h00}));
      strobe();
      check("R4 byte3", 32'(sampleOut), 32'({w[31:24], 8'h00}));
      check("R7 mono seamless", 32'(underrun), 0);
    end

    // R9: flush mid-word, pointer rewinds, staged word dropped
    writeWord(32'h4433_2211);
    strobe();
    strobe();
    writeWord(32'h8877_6655);
    enable = 1'b0; cyc();
    check("R9 sample cleared", 32'(sampleOut), 0);
    check("R9 req cleared", 32'(dataReq), 0);
    enable = 1'b1; cyc();
    strobe();
    check("R9 staged dropped", 32'(underrun), 1);
    underrunClr = 1'b1; cyc(); underrunClr = 1'b0;
    writeWord(32'hCCBB_AA99);
    strobe();
    check("R9 pointer rewound", 32'(sampleOut), 32'h0000_9900);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule